// File: doc/BRIEF.md
# Stereo Serial Sample Transmitter

This block takes stereo sample pairs from a parallel source and shifts them out, one channel at a time, on a single serial data line. The bit clock, the word clock and the left/right clock all come from an external master. The block samples them on its own system clock through synchronisers and acts on their edges. The left/right clock runs without pause, and its level says which channel occupies the current word slot. A high level selects left and a low level selects right.

Static configuration inputs choose four things:

- **Framing source.** Either every left/right transition or every rising word-clock edge starts a word.
- **Start delay.** The first bit can be held back by one bit-clock period.
- **Launch edge.** This picks which bit-clock edge moves the data line.
- **Word length.** Each channel carries 4 to 24 bits.

Samples enter through a one-entry holding buffer with a ready/valid handshake. A buffered pair goes live only when a left word starts. If no fresh pair is waiting at that moment, the previous pair is sent again.

Top module: `stereo_serial_tx`

## Requirements
- R1: After reset `ser_data` is 0 and `s_ready` is 1. Until a pair has been accepted and a left word has started, the transmitted samples are all zeros.
- R2: Each word is the top L bits of the 24-bit twos-complement sample, sent MSB first (sample bit 23 first), one bit per launch edge of the bit clock.
- R3: `cfg_word_len` sets L. Values below 4 act as 4, and values above 24 act as 24.
- R4: With `cfg_lr_trigger` = 1, every transition of `ser_lrclk` starts a word. The level of `ser_lrclk` after the transition selects the channel (1 = left, 0 = right).
- R5: With `cfg_lr_trigger` = 0, only a rising edge of `ser_wclk` starts a word, and transitions of `ser_lrclk` start none. The channel is the `ser_lrclk` level at that edge.
- R6: With `cfg_msb_delay` = 1, the first launch edge at or after the framing event drives 0, and the MSB follows on the next launch edge. With `cfg_msb_delay` = 0, the MSB goes out on the first launch edge.
- R7: With `cfg_bclk_invert` = 0, the data moves after falling bit-clock edges and is stable around rising edges. With `cfg_bclk_invert` = 1, this is reversed.
- R8: After the last bit of a word, and in any slot before the first bit, the line is 0 until the next framing event.
- R9: `s_ready` is high while the holding buffer is empty. An accepted pair drops `s_ready` on the next cycle. The pair becomes the transmitted pair at the next left word start, and `s_ready` returns high then.
- R10: If no pair is waiting when a left word starts, the previously transmitted pair is sent again.
- R11: `ser_data` changes only in the system cycle that follows a detected launch edge, at most three system cycles after that bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lr_trigger | input | 1 | 1: left/right transitions frame words; 0: word-clock rising edges frame words |
| cfg_msb_delay | input | 1 | 1: one-bit-period gap before the MSB |
| cfg_bclk_invert | input | 1 | 0: launch on falling bit-clock edges; 1: launch on rising edges |
| cfg_word_len | input | 5 | Bits per channel word, clamped to 4..24 |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding buffer empty |
| s_left | input | 24 | Left sample, left-aligned twos complement |
| s_right | input | 24 | Right sample, left-aligned twos complement |
| ser_bclk | input | 1 | External bit clock |
| ser_wclk | input | 1 | External word clock |
| ser_lrclk | input | 1 | External left/right clock |
| ser_data | output | 1 | Serial data out |

## Verification
The assertions assume that the serial clocks are slow relative to the system clock, with each bit-clock half period lasting several system cycles. They also assume that the configuration stays static outside reset and that framing events coincide with launch edges or fall between them. The stimulus meets these assumptions:

- **Clock timing.** Each bit-clock half period lasts six system cycles.
- **Clock changes.** Left/right and word-clock changes are applied only together with a launch edge.
- **Configuration.** Settings change only while reset is held.
- **Word fit.** Slots are wide enough that a full word plus delay and word-clock offset always fits.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
  typedef enum logic {
    TRIG_WCLK = 1'b0,
    TRIG_LR   = 1'b1
  } trig_e;

  localparam int unsigned LINE_BCLK = 0;
  localparam int unsigned LINE_WCLK = 1;
  localparam int unsigned LINE_LR   = 2;
  localparam int unsigned LINE_CNT  = 3;
endpackage

// File: rtl/sstx_edge_sync.sv
module sstx_edge_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_in[i]};
        prev_q  <= chain_q[STAGES-1];
      end
    end
    assign level[i] = chain_q[STAGES-1];
    assign rise[i]  = chain_q[STAGES-1] & ~prev_q;
    assign fall[i]  = ~chain_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/sstx_pair_buf.sv
module sstx_pair_buf #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_right,
  input  logic         frame,
  input  logic         chan_left,
  output logic [W-1:0] word
);
  logic         full_q;
  logic [W-1:0] hold_l_q, hold_r_q, live_l_q, live_r_q;

  assign in_ready = ~full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q   <= 1'b0;
      hold_l_q <= '0;
      hold_r_q <= '0;
      live_l_q <= '0;
      live_r_q <= '0;
    end else begin
      if (frame && chan_left) begin
        if (full_q) begin
          live_l_q <= hold_l_q;
          live_r_q <= hold_r_q;
        end
        full_q <= 1'b0;
      end
      if (in_valid && !full_q) begin
        hold_l_q <= in_left;
        hold_r_q <= in_right;
        full_q   <= 1'b1;
      end
    end
  end

  always_comb begin
    if (chan_left) word = full_q ? hold_l_q : live_l_q;
    else           word = live_r_q;
  end

  // R9: an accepted pair fills the buffer, so ready drops next cycle
  a_r9_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter #(
  parameter int W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame,
  input  logic                     launch,
  input  logic                     msb_dly,
  input  logic [$clog2(W+1)-1:0]   len,
  input  logic [W-1:0]             word,
  output logic                     ser_data
);
  localparam int CW = $clog2(W+1);

  logic [W-1:0]  sh_q, sh_n, f_sh;
  logic [CW-1:0] cnt_q, cnt_n, f_cnt;
  logic          skip_q, skip_n, f_skip;
  logic          data_q, data_n;

  always_comb begin
    f_sh   = sh_q;
    f_cnt  = cnt_q;
    f_skip = skip_q;
    if (frame) begin
      f_sh   = word;
      f_cnt  = len;
      f_skip = msb_dly;
    end
    sh_n   = f_sh;
    cnt_n  = f_cnt;
    skip_n = f_skip;
    data_n = data_q;
    if (launch) begin
      if (f_skip) begin
        skip_n = 1'b0;
        data_n = 1'b0;
      end else if (f_cnt != '0) begin
        data_n = f_sh[W-1];
        sh_n   = f_sh << 1;
        cnt_n  = f_cnt - 1'b1;
      end else begin
        data_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      skip_q <= 1'b0;
      data_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      skip_q <= skip_n;
      data_q <= data_n;
    end
  end

  assign ser_data = data_q;

  // R11: the line moves only right after a launch edge
  a_r11_moves_on_launch: assert property (@(posedge clk) disable iff (rst)
    (data_q != $past(data_q)) |-> $past(launch));
  // R8: an exhausted word leaves the line low
  a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
    (launch && !frame && !skip_q && cnt_q == '0) |=> !data_q);
  // R6: the delayed start emits a zero first
  a_r6_delay_gap: assert property (@(posedge clk) disable iff (rst)
    (frame && msb_dly && launch) |=> !data_q);
  // R3: remaining bit count never exceeds the widest word
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(W));
endmodule

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx #(
  parameter int W       = 24,
  parameter int MIN_LEN = 4,
  parameter int STAGES  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_lr_trigger,
  input  logic                   cfg_msb_delay,
  input  logic                   cfg_bclk_invert,
  input  logic [$clog2(W+1)-1:0] cfg_word_len,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [W-1:0]           s_left,
  input  logic [W-1:0]           s_right,
  input  logic                   ser_bclk,
  input  logic                   ser_wclk,
  input  logic                   ser_lrclk,
  output logic                   ser_data
);
  import sstx_pkg::*;
  localparam int LW = $clog2(W+1);

  logic [LINE_CNT-1:0] lines, lvl, rise, fall;
  logic                launch, frame, chan_left;
  logic [LW-1:0]       len_c;
  logic [W-1:0]        word;
  trig_e               trig;

  always_comb begin
    lines            = '0;
    lines[LINE_BCLK] = ser_bclk;
    lines[LINE_WCLK] = ser_wclk;
    lines[LINE_LR]   = ser_lrclk;
  end

  sstx_edge_sync #(.N(LINE_CNT), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(lines),
    .level(lvl), .rise(rise), .fall(fall)
  );

  assign trig      = trig_e'(cfg_lr_trigger);
  assign launch    = cfg_bclk_invert ? rise[LINE_BCLK] : fall[LINE_BCLK];
  assign frame     = (trig == TRIG_LR) ? (rise[LINE_LR] | fall[LINE_LR])
                                       : rise[LINE_WCLK];
  assign chan_left = lvl[LINE_LR];

  always_comb begin
    if (cfg_word_len < LW'(MIN_LEN))  len_c = LW'(MIN_LEN);
    else if (cfg_word_len > LW'(W))   len_c = LW'(W);
    else                              len_c = cfg_word_len;
  end

  sstx_pair_buf #(.W(W)) u_buf (
    .clk(clk), .rst(rst), .in_valid(s_valid), .in_ready(s_ready),
    .in_left(s_left), .in_right(s_right),
    .frame(frame), .chan_left(chan_left), .word(word)
  );

  sstx_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .frame(frame), .launch(launch),
    .msb_dly(cfg_msb_delay), .len(len_c), .word(word), .ser_data(ser_data)
  );

  // R5: in word-clock mode a lone left/right change never loads a word
  a_r5_lr_ignored: assert property (@(posedge clk) disable iff (rst)
    (trig == TRIG_WCLK && !rise[LINE_WCLK]) |-> !frame);
endmodule

// File: tb/stereo_serial_tx_tb_top.sv
module stereo_serial_tx_tb_top;
  localparam int W = 24, LW = 5, H = 6, SLOTS = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic cfg_lr_trigger = 1'b1, cfg_msb_delay = 1'b0, cfg_bclk_invert = 1'b0;
  logic [LW-1:0] cfg_word_len = LW'(24);
  logic s_valid = 1'b0, s_ready;
  logic [W-1:0] s_left = '0, s_right = '0;
  logic ser_bclk = 1'b1, ser_wclk = 1'b0, ser_lrclk = 1'b0, ser_data;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] m_act_l, m_act_r, m_buf_l, m_buf_r;
  logic m_bufv;

  stereo_serial_tx dut_i (
    .clk(clk), .rst(rst), .cfg_lr_trigger(cfg_lr_trigger),
    .cfg_msb_delay(cfg_msb_delay), .cfg_bclk_invert(cfg_bclk_invert),
    .cfg_word_len(cfg_word_len), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .ser_bclk(ser_bclk),
    .ser_wclk(ser_wclk), .ser_lrclk(ser_lrclk), .ser_data(ser_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int clampl(input int v);
    if (v < 4) return 4;
    if (v > 24) return 24;
    return v;
  endfunction

  function automatic logic exp_bit(input logic [W-1:0] s, input int len,
                                   input int k, input int d, input int off);
    int j;
    j = k - off - d;
    if (j >= 0 && j < len) return s[W-1-j];
    return 1'b0;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    s_valid = 1'b0;
    ser_wclk = 1'b0;
    ser_lrclk = 1'b0;
    ser_bclk = ~cfg_bclk_invert;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    m_act_l = '0; m_act_r = '0; m_bufv = 1'b0;
    @(negedge clk);
    chk("R1 ser_data", 32'(ser_data), 32'd0);
    chk("R1 s_ready", 32'(s_ready), 32'd1);
  endtask

  task automatic offer(input bit give);
    chk("R9 ready before offer", 32'(s_ready), 32'd1);
    if (give) begin
      s_left = W'($urandom);
      s_right = W'($urandom);
      s_valid = 1'b1;
      @(negedge clk);
      s_valid = 1'b0;
      chk("R9 ready after accept", 32'(s_ready), 32'd0);
      m_buf_l = s_left; m_buf_r = s_right; m_bufv = 1'b1;
    end
  endtask

  task automatic run_frame(input string tag, input int len, input int d,
                           input int off, input bit give, input bit first);
    logic early, e;
    logic [W-1:0] smp;
    string t, ft;
    offer(give);
    ft = give ? tag : (first ? "R1" : "R10");
    if (m_bufv) begin
      m_act_l = m_buf_l; m_act_r = m_buf_r; m_bufv = 1'b0;
    end
    for (int ch = 0; ch < 2; ch++) begin
      smp = (ch == 0) ? m_act_l : m_act_r;
      for (int k = 0; k < SLOTS; k++) begin
        if (k == 0) ser_lrclk = (ch == 0);
        if (!cfg_lr_trigger) begin
          if (k == off) ser_wclk = 1'b1;
          else if (k == off + 1) ser_wclk = 1'b0;
        end
        ser_bclk = cfg_bclk_invert;
        repeat (H - 2) @(negedge clk);
        early = ser_data;
        repeat (2) @(negedge clk);
        e = exp_bit(smp, len, k, d, off);
        if (k >= off && k < off + d) t = "R6 delay slot";
        else if (k < off || k - off - d >= len) t = "R8 idle slot";
        else t = {"R2 data bit ", ft};
        chk({t, " ", tag}, 32'(ser_data), 32'(e));
        chk("R11 stable before capture", 32'(ser_data), 32'(early));
        ser_bclk = ~cfg_bclk_invert;
        repeat (H) @(negedge clk);
      end
    end
  endtask

  task automatic run(input bit trig, input bit inv, input bit dly, input int cl,
                     input int off, input string tag, input bit [2:0] gives);
    cfg_lr_trigger = trig;
    cfg_bclk_invert = inv;
    cfg_msb_delay = dly;
    cfg_word_len = LW'(cl);
    do_reset();
    for (int f = 0; f < 3; f++)
      run_frame(tag, clampl(cl), int'(dly), off, gives[f], f == 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4813);
    run(1'b1, 1'b0, 1'b0, 24, 0, "R4", 3'b110);
    run(1'b1, 1'b1, 1'b1, 4, 0, "R7", 3'b101);
    run(1'b0, 1'b0, 1'b1, 16, 2, "R5", 3'b111);
    run(1'b0, 1'b1, 1'b0, 9, 1, "R5", 3'b011);
    run(1'b1, 1'b0, 1'b0, 2, 0, "R3 low clamp", 3'b111);
    run(1'b1, 1'b1, 1'b0, 31, 0, "R3 high clamp", 3'b111);
    for (int i = 0; i < 6; i++) begin
      bit tr;
      tr = 1'($urandom);
      run(tr, 1'($urandom), 1'($urandom), 4 + int'($urandom % 21),
          tr ? 0 : int'($urandom % 3), "R2 random", 3'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule